// File: doc/BRIEF.md
# Long-Instruction-Word Issue Stage

This block sits between an instruction memory and five functional units of a statically scheduled wide-issue core. Every program-counter value names one whole long instruction word (a bundle). The bundle holds five operation slots, one shared immediate and a per-slot presence mask. When the stage accepts a bundle, it decodes all five slots side by side. In the next cycle it presents every present slot to the unit that slot is wired to. Slots 0 and 1 feed the two memory units, slots 2 and 3 feed the two floating-point units, and slot 4 feeds the integer/branch unit.

The stage trusts the static schedule completely. It performs no dependence or resource checks between slots. The one encoding check it makes is whether more than one present slot claims the shared immediate. A stall from any unit freezes the whole stage in lock-step. A taken branch reported by the integer/branch unit redirects the program counter, and the architecture has no delay slots.

The fetch side is a valid/ready stream. The memory presents the bundle for `fetch_pc` with `bndl_valid`. The stage raises `bndl_ready` only when no unit is stalling and no redirect is being taken. A bundle counts as consumed only on a cycle where both signals are high. The issue side is five parallel valid streams that share one global ready, which is the inverse of any unit stall. While any unit stalls, every issued slot holds its contents.

Top module: `vliw_issue_unit`

## Requirements
- R1: While reset is asserted and immediately after its release, `fetch_pc` is 0, every `slot_valid` bit is 0, and `illegal_err` is 0.
- R2: Bundle layout is as follows. Slot i occupies bits [32i+31:32i]. The shared immediate occupies bits [191:160]. The presence mask occupies bits [196:192], with mask bit i belonging to slot i. In the cycle after a slot issues, its 32-bit word appears unchanged on `slot_op[32i+31:32i]`.
- R3: `bndl_ready` is 1 exactly when no `unit_stall` bit is set and `br_taken` is 0. Each accepted bundle advances `fetch_pc` by one. In a cycle with `bndl_valid` low and no stall, `fetch_pc` holds and no slot is valid in the next cycle.
- R4: All present slots of an accepted legal bundle are valid together in the cycle after acceptance, and absent slots are not valid. This holds even when several slots carry identical words, because no intra-bundle checking is done.
- R5: A bundle whose mask is 0 is still accepted. It advances `fetch_pc` by one and leaves every `slot_valid` low.
- R6: Bit 31 of a slot word requests the shared immediate. The slot's `slot_opnd` output carries the immediate if its slot requested it, and carries 0 otherwise.
- R7: If two or more present slots request the immediate, the bundle is consumed without issuing any slot. `illegal_err` is 1 in the next cycle and `fetch_pc` still advances. Requests made by absent slots do not count.
- R8: While any `unit_stall` bit is 1, `fetch_pc`, every slot output and `illegal_err` keep their values.
- R9: When `br_taken` is 1 and no unit stalls, `fetch_pc` loads `br_target` in the next cycle, the bundle presented in that cycle is not accepted, and no slot is valid afterwards. While any unit stalls, `br_taken` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | output | PC_W | Bundle address requested from instruction memory |
| bndl_valid | input | 1 | Instruction memory presents the bundle for `fetch_pc` |
| bndl_ready | output | 1 | Stage can consume a bundle this cycle |
| bndl_data | input | 197 | Bundle: five slots, shared immediate, presence mask |
| unit_stall | input | 5 | Per-unit stall, bit i from the unit of slot i |
| br_taken | input | 1 | Integer/branch unit reports a taken branch |
| br_target | input | PC_W | Bundle address of the branch target |
| slot_valid | output | 5 | Per-slot issue valid |
| slot_op | output | 160 | Issued slot words, 32 bits per slot |
| slot_opnd | output | 160 | Per-slot immediate operand, 32 bits per slot |
| illegal_err | output | 1 | Last consumed bundle had conflicting immediate requests |

## Verification
The bench targets the corner cases below and the failure each one exposes:

- **Empty bundle.** A design that skipped the empty bundle would leave the PC where it was.
- **Conflicting immediate claims.** A design that let this bundle issue would show valid slots where none are allowed.
- **Claims from absent slots.** A design that counted these would reject a legal bundle.
- **Stall on a single unit.** A design that stalled only the affected unit would change other slots or the PC while the stall was active.
- **Redirect during a stall.** A design that honoured it would move the PC.
- **Redirect alongside a presented bundle.** A design that also consumed that bundle would issue a wrong-path operation, breaking the no-delay-slot rule.
- **Immediate routing.** The bench checks that the immediate reaches only the slot that asked for it.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
  localparam int NSLOT   = 5;
  localparam int SLOT_W  = 32;
  localparam int IMM_W   = 32;
  localparam int IMM_LO  = NSLOT * SLOT_W;
  localparam int MASK_LO = IMM_LO + IMM_W;
  localparam int BNDL_W  = MASK_LO + NSLOT;
  localparam int REQ_BIT = SLOT_W - 1;

  typedef enum logic [1:0] {
    UC_MEM = 2'd0,
    UC_FP  = 2'd1,
    UC_INT = 2'd2
  } unit_class_e;

  function automatic unit_class_e class_of(input int idx);
    if (idx < 2)      return UC_MEM;
    else if (idx < 4) return UC_FP;
    else              return UC_INT;
  endfunction
endpackage

// File: rtl/vliw_slot_dec.sv
module vliw_slot_dec
  import vliw_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic present,
  input  logic imm_req,
  output logic vld,
  output logic want_imm,
  output logic [1:0] uclass
);
  localparam unit_class_e CLS = class_of(IDX);

  assign vld      = present;
  assign want_imm = present & imm_req;
  assign uclass   = CLS;
endmodule

// File: rtl/vliw_pc_ctrl.sv
module vliw_pc_ctrl #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            accept,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (!stall) begin
      if (br_taken)    pc <= br_target;
      else if (accept) pc <= pc + 1'b1;
    end
  end

  // R8
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));
  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !br_taken) |=> pc == $past(pc) + 1'b1);
  // R9
  pc_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !stall) |=> pc == $past(br_target));
endmodule

// File: rtl/vliw_issue_reg.sv
module vliw_issue_reg
  import vliw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    accept,
  input  logic                    illegal,
  input  logic [NSLOT-1:0]        vld_d,
  input  logic [NSLOT-1:0]        want_imm,
  input  logic [NSLOT*SLOT_W-1:0] ops_d,
  input  logic [IMM_W-1:0]        imm,
  output logic [NSLOT-1:0]        valid_q,
  output logic [NSLOT*SLOT_W-1:0] op_q,
  output logic [NSLOT*IMM_W-1:0]  opnd_q,
  output logic                    err_q
);
  logic                   issue;
  logic [NSLOT*IMM_W-1:0] opnd_d;

  assign issue = accept & ~illegal;

  always_comb begin
    for (int i = 0; i < NSLOT; i++)
      opnd_d[i*IMM_W +: IMM_W] = want_imm[i] ? imm : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      op_q    <= '0;
      opnd_q  <= '0;
      err_q   <= 1'b0;
    end else if (!stall) begin
      valid_q <= issue ? vld_d : '0;
      err_q   <= accept & illegal;
      if (issue) begin
        op_q   <= ops_d;
        opnd_q <= opnd_d;
      end
    end
  end

  // R8
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(valid_q) && $stable(op_q) && $stable(err_q)));
  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !accept) |=> valid_q == '0);
  // R7
  err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> valid_q == '0);
  // R6
  one_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> $onehot0(want_imm));
endmodule

// File: rtl/vliw_issue_unit.sv
module vliw_issue_unit
  import vliw_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [PC_W-1:0]         fetch_pc,
  input  logic                    bndl_valid,
  output logic                    bndl_ready,
  input  logic [BNDL_W-1:0]       bndl_data,
  input  logic [NSLOT-1:0]        unit_stall,
  input  logic                    br_taken,
  input  logic [PC_W-1:0]         br_target,
  output logic [NSLOT-1:0]        slot_valid,
  output logic [NSLOT*SLOT_W-1:0] slot_op,
  output logic [NSLOT*IMM_W-1:0]  slot_opnd,
  output logic                    illegal_err
);
  logic                   any_stall;
  logic                   accept;
  logic                   illegal;
  logic [NSLOT-1:0]       vld_d;
  logic [NSLOT-1:0]       want_imm;
  logic [2*NSLOT-1:0]     uclass;
  logic [NSLOT*SLOT_W-1:0] ops;
  logic [IMM_W-1:0]       imm;
  logic [NSLOT-1:0]       mask;

  assign ops  = bndl_data[IMM_LO-1:0];
  assign imm  = bndl_data[MASK_LO-1:IMM_LO];
  assign mask = bndl_data[BNDL_W-1:MASK_LO];

  assign any_stall  = |unit_stall;
  assign bndl_ready = ~any_stall & ~br_taken;
  assign accept     = bndl_valid & bndl_ready;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    vliw_slot_dec #(.IDX(g)) u_dec (
      .present  (mask[g]),
      .imm_req  (ops[g*SLOT_W + REQ_BIT]),
      .vld      (vld_d[g]),
      .want_imm (want_imm[g]),
      .uclass   (uclass[2*g +: 2])
    );
  end

  // two or more requesters: clearing the lowest set bit leaves something
  assign illegal = |(want_imm & (want_imm - 1'b1));

  vliw_pc_ctrl #(.PC_W(PC_W)) u_pc (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (any_stall),
    .accept    (accept),
    .br_taken  (br_taken),
    .br_target (br_target),
    .pc        (fetch_pc)
  );

  vliw_issue_reg u_iss (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (any_stall),
    .accept   (accept),
    .illegal  (illegal),
    .vld_d    (vld_d),
    .want_imm (want_imm),
    .ops_d    (ops),
    .imm      (imm),
    .valid_q  (slot_valid),
    .op_q     (slot_op),
    .opnd_q   (slot_opnd),
    .err_q    (illegal_err)
  );

  // R4
  slot_wiring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uclass[2*NSLOT-1 -: 2] == 2'(UC_INT) && uclass[1:0] == 2'(UC_MEM));
  // R9
  redirect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> !accept);
endmodule

// File: tb/sim_vliw_issue_unit.sv
module sim_vliw_issue_unit;
  import vliw_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [15:0]             fetch_pc;
  logic                    bndl_valid = 1'b0;
  logic                    bndl_ready;
  logic [BNDL_W-1:0]       bndl_data;
  logic [NSLOT-1:0]        unit_stall = '0;
  logic                    br_taken = 1'b0;
  logic [15:0]             br_target = '0;
  logic [NSLOT-1:0]        slot_valid;
  logic [NSLOT*SLOT_W-1:0] slot_op;
  logic [NSLOT*IMM_W-1:0]  slot_opnd;
  logic                    illegal_err;

  logic [4:0]  cur_mask = '0;
  logic [4:0]  cur_flg  = '0;
  logic [31:0] cur_imm  = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vliw_issue_unit u0 (.*);

  // instruction memory model: word encodes request flag, pc and slot index
  always_comb begin
    bndl_data = '0;
    for (int i = 0; i < NSLOT; i++)
      bndl_data[i*SLOT_W +: SLOT_W] = {cur_flg[i], 19'h0, fetch_pc[7:0], 4'(i)};
    bndl_data[MASK_LO-1:IMM_LO] = cur_imm;
    bndl_data[BNDL_W-1:MASK_LO] = cur_mask;
  end

  function automatic logic [31:0] word_of(input logic f, input logic [15:0] pc, input int i);
    return {f, 19'h0, pc[7:0], 4'(i)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // {mask, imm flags, stall, expected valid, expected err, pc increment}
  localparam logic [21:0] VEC [0:9] = '{
    {5'b11111, 5'b00000, 5'b00000, 5'b11111, 1'b0, 1'b1},
    {5'b00000, 5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b1},
    {5'b10101, 5'b00100, 5'b00000, 5'b10101, 1'b0, 1'b1},
    {5'b11111, 5'b00011, 5'b00000, 5'b00000, 1'b1, 1'b1},
    {5'b00011, 5'b01100, 5'b00000, 5'b00011, 1'b0, 1'b1},
    {5'b11111, 5'b00000, 5'b00100, 5'b00011, 1'b0, 1'b0},
    {5'b11111, 5'b00000, 5'b10000, 5'b00011, 1'b0, 1'b0},
    {5'b11111, 5'b00000, 5'b00000, 5'b11111, 1'b0, 1'b1},
    {5'b11111, 5'b10001, 5'b00000, 5'b00000, 1'b1, 1'b1},
    {5'b00000, 5'b00000, 5'b00001, 5'b00000, 1'b1, 1'b0}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] pc0;
    // R1: reset state
    repeat (2) step();
    chk("R1 pc in reset", 64'(fetch_pc), 64'd0);
    chk("R1 valid in reset", 64'(slot_valid), 64'd0);
    rst_n = 1'b1;
    step();
    chk("R1 pc after release", 64'(fetch_pc), 64'd0);
    chk("R1 err after release", 64'(illegal_err), 64'd0);

    // table walk: R3 R4 R5 R7 R8
    bndl_valid = 1'b1;
    for (int k = 0; k < 10; k++) begin
      cur_mask   = VEC[k][21:17];
      cur_flg    = VEC[k][16:12];
      unit_stall = VEC[k][11:7];
      cur_imm    = 32'h1000 + 32'(k);
      pc0 = fetch_pc;
      #0;
      chk("R3 ready", 64'(bndl_ready), 64'(VEC[k][11:7] == 5'b0));
      step();
      chk("R4/R5/R8 valid", 64'(slot_valid), 64'(VEC[k][6:2]));
      chk("R7/R8 err", 64'(illegal_err), 64'(VEC[k][1]));
      chk("R3/R5/R8 pc", 64'(fetch_pc), 64'(pc0 + 16'(VEC[k][0])));
    end
    unit_stall = '0;

    // R6 and R2: immediate routing and slot word passthrough
    cur_mask = 5'b11111;
    cur_flg  = 5'b01000;
    cur_imm  = 32'hCAFE_0123;
    pc0 = fetch_pc;
    step();
    chk("R6 opnd slot3", 64'(slot_opnd[3*32 +: 32]), 64'h0000_0000_CAFE_0123);
    chk("R6 opnd slot0 zero", 64'(slot_opnd[0 +: 32]), 64'd0);
    chk("R6 opnd slot4 zero", 64'(slot_opnd[4*32 +: 32]), 64'd0);
    chk("R2 op slot3", 64'(slot_op[3*32 +: 32]), 64'(word_of(1'b1, pc0, 3)));
    chk("R2 op slot4", 64'(slot_op[4*32 +: 32]), 64'(word_of(1'b0, pc0, 4)));

    // R3: no bundle offered
    bndl_valid = 1'b0;
    pc0 = fetch_pc;
    step();
    chk("R3 idle pc holds", 64'(fetch_pc), 64'(pc0));
    chk("R3 idle no valid", 64'(slot_valid), 64'd0);

    // R9: redirect with a bundle presented
    bndl_valid = 1'b1;
    cur_flg    = '0;
    br_taken   = 1'b1;
    br_target  = 16'h0040;
    #0;
    chk("R9 ready low on redirect", 64'(bndl_ready), 64'd0);
    step();
    chk("R9 pc loads target", 64'(fetch_pc), 64'h40);
    chk("R9 wrong-path not issued", 64'(slot_valid), 64'd0);

    // R9: redirect ignored while stalled
    unit_stall = 5'b00010;
    br_target  = 16'h0080;
    step();
    chk("R9 redirect ignored in stall", 64'(fetch_pc), 64'h40);
    br_taken   = 1'b0;
    unit_stall = '0;
    step();
    chk("R9 target bundle issued", 64'(slot_valid), 64'h1f);
    chk("R2 op from target", 64'(slot_op[0 +: 32]), 64'(word_of(1'b0, 16'h40, 0)));
    chk("R3 pc after target", 64'(fetch_pc), 64'h41);

    finish_run();
  end
endmodule